// File: doc/BRIEF.md
# SD Data Line Serializer with CRC16

This block moves data between a byte stream and the data lines of an SD-style card bus. On transmit it takes bytes through a valid/ready handshake. It frames them with a start bit, appends a CRC16 for each active line and closes the block with an end bit. It then releases the lines and keeps busy asserted while the card holds data line 0 low. On receive it waits for a start bit on line 0, rebuilds bytes and emits one pulse per byte. At the end of the block it reports a CRC mismatch or a bad end bit together with the end-of-block pulse.

Software selects the bus width with a two-bit size code. Code 0 gives a 1-bit bus on line 0. Code 1 gives a 4-bit bus on lines 3 down to 0. The two reserved codes fall back to the 1-bit bus. Each clock cycle carries one bus slot: one bit per line. The width and the block length are captured when a block starts. A start request is taken only while both directions are idle.

Top module: `sd_data_line`

## Requirements
- R1: With size code 0, each byte goes out on line 0 as eight slots, one per clock, most significant bit first.
- R2: With size code 1, each byte goes out as two slots, high nibble first, with nibble bit i on line i (bit 3 on line 3).
- R3: Size codes 2 and 3 behave exactly like code 0, for both transmit and receive.
- R4: During a 1-bit frame, output enables 3 to 1 stay low. All output enables are low after reset, during receive and whenever no transmit frame is in progress.
- R5: A transmit frame drives all active lines high while it waits for the first byte. It then sends one start slot of 0 on every active line, then the data slots, then 16 CRC slots and one end slot of 1. After that the output enables drop.
- R6: The CRC of each active line uses polynomial 0x1021 (x^16+x^12+x^5+1) with a zero start value. It covers only the data bits of that line and is sent most significant bit first. In 4-bit mode each line keeps its own independent CRC.
- R7: The 12-bit block length counts bytes, and the value 0 means 4096 bytes.
- R8: On transmit, busy_o is high from the start slot to the end slot and stays high afterwards while data line 0 is sampled low. Once line 0 is sampled high, busy_o falls and eob_o pulses high for exactly one cycle.
- R9: On receive, the first slot with line 0 low is the start bit. Data slots follow in the same bit order as R1/R2, and each completed byte appears on rx_data_o with a one-cycle rx_valid_o pulse in the cycle after its last slot.
- R10: On receive, crc_err_o pulses with eob_o when the CRC of any active line does not match the 16 received CRC slots.
- R11: On receive, fmt_err_o pulses with eob_o when any active line carries 0 in the end slot.
- R12: tx_ready_o is high while the first byte is awaited and in the last slot of every byte except the final one. Exactly the block length in bytes is accepted per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_size_i | input | 2 | Bus width code: 0 = 1-bit, 1 = 4-bit, 2/3 = 1-bit |
| dir_tx_i | input | 1 | 1 = transmit block, 0 = receive block |
| enable_i | input | 1 | Starts a block when both directions are idle |
| blk_len_i | input | 12 | Block length in bytes, 0 means 4096 |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit byte accepted at this edge when valid |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle pulse per received byte |
| dat_i | input | 4 | Data lines as seen on the bus |
| dat_o | output | 4 | Data line drive values |
| dat_oe_o | output | 4 | Per-line output enables |
| busy_o | output | 1 | Block on the bus, or card busy after a write |
| eob_o | output | 1 | One-cycle end-of-block pulse |
| crc_err_o | output | 1 | Receive CRC mismatch, valid with eob_o |
| fmt_err_o | output | 1 | Receive end-bit error, valid with eob_o |

## Verification
The bench builds the block with its default parameters: a 12-bit length field, the 0x1021 polynomial and four data lines. With these values, length code 0 produces a full 4096-byte block. In 4-bit mode that block needs about 8200 cycles, so the count wrap of the length field is checked directly. The bench keeps its own CRC for each line. This lets it catch a single corrupted CRC bit on line 2 and a bad end bit on line 3 in 4-bit mode, beside the 1-bit cases and the reserved size codes.

// File: rtl/sdl_pkg.sv
`timescale 1ns/1ps
package sdl_pkg;
  localparam int unsigned LANES   = 4;
  localparam int unsigned CRC_W   = 16;
  localparam int unsigned CRC_CNT = $clog2(CRC_W);

  typedef enum logic [2:0] {
    TX_IDLE, TX_PRE, TX_START, TX_DATA, TX_CRC, TX_END, TX_BUSY
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_WAIT, RX_DATA, RX_CRC, RX_END
  } rx_state_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                               input logic b,
                                               input logic [CRC_W-1:0] poly);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/sdl_crc_lane.sv
`timescale 1ns/1ps
module sdl_crc_lane
  import sdl_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_o <= '0;
    else if (clr_i)   crc_o <= '0;
    else if (step_i)  crc_o <= crc_step(crc_o, bit_i, POLY);
    else if (shift_i) crc_o <= {crc_o[CRC_W-2:0], 1'b0};
  end

  AST_CRC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_o == '0); // R6
endmodule

// File: rtl/sdl_tx.sv
`timescale 1ns/1ps
module sdl_tx
  import sdl_pkg::*;
#(
  parameter int unsigned      LEN_W = 12,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wide_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  input  logic             dat0_i,
  output logic [LANES-1:0] dat_o,
  output logic [LANES-1:0] dat_oe_o,
  output logic             busy_o,
  output logic             idle_o,
  output logic             eob_o
);
  tx_state_e            state_q;
  logic [7:0]           sh_q;
  logic [2:0]           slot_q;
  logic [LEN_W-1:0]     left_q;
  logic [CRC_CNT-1:0]   cnt_q;
  logic                 wide_q;
  logic                 eob_q;

  logic [LANES-1:0]     mask;
  logic [LANES-1:0]     lane_bits;
  logic [LANES-1:0]     crc_msb;
  logic                 last_slot;
  logic                 need_next;
  logic                 adv;
  logic [CRC_W-1:0]     crc_w [LANES];

  assign mask      = wide_q ? {LANES{1'b1}} : {{(LANES-1){1'b0}}, 1'b1};
  assign lane_bits = wide_q ? sh_q[7:4] : {{(LANES-1){1'b0}}, sh_q[7]};
  assign last_slot = wide_q ? (slot_q == 3'd1) : (slot_q == 3'd7);
  assign need_next = (state_q == TX_DATA) && last_slot && (left_q != '0);
  assign adv       = (state_q == TX_DATA) && (!need_next || tx_valid_i);

  assign tx_ready_o = (state_q == TX_PRE) || need_next;
  assign busy_o     = (state_q != TX_IDLE) && (state_q != TX_PRE);
  assign idle_o     = (state_q == TX_IDLE);
  assign eob_o      = eob_q;

  for (genvar l = 0; l < LANES; l++) begin : g_crc
    sdl_crc_lane #(.POLY(POLY)) u_crc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (state_q == TX_PRE),
      .step_i  (adv),
      .shift_i (state_q == TX_CRC),
      .bit_i   (lane_bits[l]),
      .crc_o   (crc_w[l])
    );
    assign crc_msb[l] = crc_w[l][CRC_W-1];
  end

  always_comb begin
    dat_o    = '0;
    dat_oe_o = '0;
    unique case (state_q)
      TX_PRE:   begin dat_o = mask;             dat_oe_o = mask; end
      TX_START: begin dat_o = '0;               dat_oe_o = mask; end
      TX_DATA:  begin dat_o = lane_bits;        dat_oe_o = mask; end
      TX_CRC:   begin dat_o = crc_msb & mask;   dat_oe_o = mask; end
      TX_END:   begin dat_o = mask;             dat_oe_o = mask; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      slot_q  <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
      wide_q  <= 1'b0;
      eob_q   <= 1'b0;
    end else begin
      eob_q <= 1'b0;
      unique case (state_q)
        TX_IDLE: if (start_i) begin
          wide_q  <= wide_i;
          left_q  <= len_i - 1'b1;  // 0 wraps to the full 2^LEN_W block
          state_q <= TX_PRE;
        end
        TX_PRE: if (tx_valid_i) begin
          sh_q    <= tx_data_i;
          slot_q  <= '0;
          state_q <= TX_START;
        end
        TX_START: state_q <= TX_DATA;
        TX_DATA: if (adv) begin
          if (last_slot) begin
            slot_q <= '0;
            if (left_q != '0) begin
              sh_q   <= tx_data_i;
              left_q <= left_q - 1'b1;
            end else begin
              cnt_q   <= '0;
              state_q <= TX_CRC;
            end
          end else begin
            sh_q   <= wide_q ? {sh_q[3:0], 4'b0000} : {sh_q[6:0], 1'b0};
            slot_q <= slot_q + 3'd1;
          end
        end
        TX_CRC: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CRC_CNT'(CRC_W-1)) state_q <= TX_END;
        end
        TX_END: state_q <= TX_BUSY;
        TX_BUSY: if (dat0_i) begin
          eob_q   <= 1'b1;
          state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  AST_TX_NARROW_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_q |-> dat_oe_o[LANES-1:1] == '0); // R4
  AST_TX_CRC_TO_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_CRC && cnt_q == CRC_CNT'(CRC_W-1)) |=> state_q == TX_END); // R5
  AST_TX_END_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == TX_END |=> (busy_o && dat_oe_o == '0)); // R8
  AST_TX_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_BUSY && !dat0_i) |=> busy_o); // R8
  AST_TX_EOB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eob_o |=> !eob_o); // R8
  AST_TX_BYTE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (need_next && tx_valid_i) |=> left_q == $past(left_q) - 1'b1); // R12
endmodule

// File: rtl/sdl_rx.sv
`timescale 1ns/1ps
module sdl_rx
  import sdl_pkg::*;
#(
  parameter int unsigned      LEN_W = 12,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wide_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LANES-1:0] dat_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  output logic             busy_o,
  output logic             idle_o,
  output logic             eob_o,
  output logic             crc_err_o,
  output logic             fmt_err_o
);
  rx_state_e            state_q;
  logic [7:0]           sh_q;
  logic [2:0]           slot_q;
  logic [LEN_W-1:0]     left_q;
  logic [CRC_CNT-1:0]   cnt_q;
  logic                 wide_q;

  logic [LANES-1:0]     mask;
  logic [LANES-1:0]     lane_bits;
  logic [LANES-1:0]     crc_nz;
  logic [7:0]           next_byte;
  logic                 last_slot;
  logic                 crc_step_en;
  logic [CRC_W-1:0]     crc_w [LANES];

  assign mask        = wide_q ? {LANES{1'b1}} : {{(LANES-1){1'b0}}, 1'b1};
  assign lane_bits   = wide_q ? dat_i : {{(LANES-1){1'b0}}, dat_i[0]};
  assign last_slot   = wide_q ? (slot_q == 3'd1) : (slot_q == 3'd7);
  assign next_byte   = wide_q ? {sh_q[3:0], dat_i} : {sh_q[6:0], dat_i[0]};
  assign crc_step_en = (state_q == RX_DATA) || (state_q == RX_CRC);

  assign busy_o = (state_q == RX_DATA) || (state_q == RX_CRC) || (state_q == RX_END);
  assign idle_o = (state_q == RX_IDLE);

  // Received CRC bits run through the same register; a match leaves zero.
  for (genvar l = 0; l < LANES; l++) begin : g_crc
    sdl_crc_lane #(.POLY(POLY)) u_crc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (state_q == RX_WAIT),
      .step_i  (crc_step_en),
      .shift_i (1'b0),
      .bit_i   (lane_bits[l]),
      .crc_o   (crc_w[l])
    );
    assign crc_nz[l] = |crc_w[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_IDLE;
      sh_q       <= '0;
      slot_q     <= '0;
      left_q     <= '0;
      cnt_q      <= '0;
      wide_q     <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      eob_o      <= 1'b0;
      crc_err_o  <= 1'b0;
      fmt_err_o  <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      eob_o      <= 1'b0;
      crc_err_o  <= 1'b0;
      fmt_err_o  <= 1'b0;
      unique case (state_q)
        RX_IDLE: if (start_i) begin
          wide_q  <= wide_i;
          left_q  <= len_i - 1'b1;
          state_q <= RX_WAIT;
        end
        RX_WAIT: if (!dat_i[0]) begin
          slot_q  <= '0;
          state_q <= RX_DATA;
        end
        RX_DATA: begin
          sh_q <= next_byte;
          if (last_slot) begin
            slot_q     <= '0;
            rx_data_o  <= next_byte;
            rx_valid_o <= 1'b1;
            if (left_q == '0) begin
              cnt_q   <= '0;
              state_q <= RX_CRC;
            end else begin
              left_q <= left_q - 1'b1;
            end
          end else begin
            slot_q <= slot_q + 3'd1;
          end
        end
        RX_CRC: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CRC_CNT'(CRC_W-1)) state_q <= RX_END;
        end
        RX_END: begin
          eob_o     <= 1'b1;
          crc_err_o <= |(crc_nz & mask);
          fmt_err_o <= |(~dat_i & mask);
          state_q   <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  AST_RX_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_WAIT && !dat_i[0]) |=> busy_o); // R9
  AST_RX_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R9
  AST_RX_CRC_ERR_EOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> eob_o); // R10
  AST_RX_FMT_ERR_EOB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> eob_o); // R11
  AST_RX_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == RX_END |=> (!busy_o && eob_o)); // R10
endmodule

// File: rtl/sd_data_line.sv
`timescale 1ns/1ps
module sd_data_line
  import sdl_pkg::*;
#(
  parameter int unsigned      LEN_W = 12,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       bus_size_i,
  input  logic             dir_tx_i,
  input  logic             enable_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic [LANES-1:0] dat_i,
  output logic [LANES-1:0] dat_o,
  output logic [LANES-1:0] dat_oe_o,
  output logic             busy_o,
  output logic             eob_o,
  output logic             crc_err_o,
  output logic             fmt_err_o
);
  logic wide;
  logic tx_idle, rx_idle, tx_busy, rx_busy, tx_eob, rx_eob;
  logic tx_start, rx_start;

  // Reserved codes fall back to the 1-bit bus.
  assign wide     = (bus_size_i == 2'd1);
  assign tx_start = enable_i &&  dir_tx_i && tx_idle && rx_idle;
  assign rx_start = enable_i && !dir_tx_i && tx_idle && rx_idle;

  sdl_tx #(.LEN_W(LEN_W), .POLY(POLY)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (tx_start),
    .wide_i     (wide),
    .len_i      (blk_len_i),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .dat0_i     (dat_i[0]),
    .dat_o      (dat_o),
    .dat_oe_o   (dat_oe_o),
    .busy_o     (tx_busy),
    .idle_o     (tx_idle),
    .eob_o      (tx_eob)
  );

  sdl_rx #(.LEN_W(LEN_W), .POLY(POLY)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (rx_start),
    .wide_i     (wide),
    .len_i      (blk_len_i),
    .dat_i      (dat_i),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .busy_o     (rx_busy),
    .idle_o     (rx_idle),
    .eob_o      (rx_eob),
    .crc_err_o  (crc_err_o),
    .fmt_err_o  (fmt_err_o)
  );

  assign busy_o = tx_busy | rx_busy;
  assign eob_o  = tx_eob | rx_eob;

  AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_busy && rx_busy)); // R4
  AST_RX_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_busy |-> dat_oe_o == '0); // R4
endmodule

// File: tb/sim_sd_data_line.sv
`timescale 1ns/1ps
module sim_sd_data_line;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_size;
  logic        dir_tx, enable;
  logic [11:0] blk_len;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic [3:0]  dat_in, dat_out, dat_oe;
  logic        busy, eob, crc_err, fmt_err;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  sd_data_line u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_size_i(bus_size), .dir_tx_i(dir_tx),
    .enable_i(enable), .blk_len_i(blk_len), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .dat_i(dat_in), .dat_o(dat_out), .dat_oe_o(dat_oe),
    .busy_o(busy), .eob_o(eob), .crc_err_o(crc_err), .fmt_err_o(fmt_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed + k * 37 + (k >> 3));
  endfunction

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
    logic fb;
    fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  task automatic tx_frame(input logic [1:0] bs, input int len_code, input int seed,
                          input int hold, input string rq);
    bit wide = (bs == 2'd1);
    logic [3:0] m = wide ? 4'hF : 4'h1;
    int nb = (len_code == 0) ? 4096 : len_code;
    int spb = wide ? 2 : 8;
    logic [15:0] crc [4];
    logic [3:0] ex;
    int idx = 0, accepted = 0, bad = 0, bad_oe = 0, bad_busy = 0;
    bit acc;
    for (int l = 0; l < 4; l++) crc[l] = '0;
    @(negedge clk);
    dir_tx = 1'b1; bus_size = bs; blk_len = 12'(len_code); enable = 1'b1;
    @(negedge clk);
    enable = 1'b0; tx_valid = 1'b1; tx_data = pat(seed, 0);
    chk(tx_ready && !busy && dat_oe == m && (dat_out & m) == m, "R12",
        "ready and idle-high before start", {dat_oe, 3'b0, tx_ready}, {m, 4'h1});
    acc = tx_ready && tx_valid;
    @(negedge clk);
    if (acc) begin accepted++; idx++; tx_data = pat(seed, idx); if (idx >= nb) tx_valid = 1'b0; end
    acc = tx_ready && tx_valid;
    chk(busy && (dat_out & m) == 0 && dat_oe == m, "R5", "start slot",
        {dat_oe, dat_out}, {m, 4'h0});
    for (int s = 0; s < nb * spb; s++) begin
      logic [7:0] b;
      int j;
      @(negedge clk);
      if (acc) begin accepted++; idx++; tx_data = pat(seed, idx); if (idx >= nb) tx_valid = 1'b0; end
      acc = tx_ready && tx_valid;
      b = pat(seed, s / spb);
      j = s % spb;
      ex = wide ? ((j == 0) ? b[7:4] : b[3:0]) : {3'b000, b[7-j]};
      if ((dat_out & m) !== ex) begin
        if (bad == 0)
          $display("FAIL %s data slot %0d: actual %0h expected %0h", rq, s, dat_out & m, ex);
        bad++;
      end
      if (dat_oe !== m) bad_oe++;
      if (!busy) bad_busy++;
      for (int l = 0; l < 4; l++) crc[l] = crc_upd(crc[l], ex[l]);
    end
    chk(bad == 0, rq, "data slots mismatching", bad, 0);
    chk(bad_oe == 0, "R4", "output enable during data", bad_oe, 0);
    chk(accepted == nb && !tx_ready, "R12", "bytes accepted", accepted, nb);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) ex[l] = crc[l][15-i];
      ex = ex & m;
      if ((dat_out & m) !== ex || dat_oe !== m) bad++;
      if (!busy) bad_busy++;
    end
    chk(bad == 0, "R6", "CRC slots mismatching", bad, 0);
    @(negedge clk);
    chk((dat_out & m) == m && dat_oe == m, "R5", "end slot", {dat_oe, dat_out}, {m, m});
    dat_in = 4'hE;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!busy) bad_busy++;
      if (dat_oe != 4'h0) bad_oe++;
      if (eob) bad_busy++;
      if (h == hold - 1) dat_in = 4'hF;
    end
    chk(bad_busy == 0, "R8", "busy gaps within frame", bad_busy, 0);
    chk(bad_oe == 0, "R5", "lines released after end", bad_oe, 0);
    @(negedge clk);
    chk(eob && !busy, "R8", "eob after busy release", {eob, busy}, 2'b10);
    @(negedge clk);
    chk(!eob && dat_oe == 0, "R8", "eob single pulse", eob, 0);
  endtask

  task automatic rx_frame(input logic [1:0] bs, input int len_code, input int seed,
                          input bit crc_bad, input bit end_bad, input string rq);
    bit wide = (bs == 2'd1);
    int nb = (len_code == 0) ? 4096 : len_code;
    int spb = wide ? 2 : 8;
    logic [15:0] crc [4];
    logic [3:0] v;
    int rcount = 0, rx_bad = 0, bad_oe = 0;
    for (int l = 0; l < 4; l++) crc[l] = '0;
    @(negedge clk);
    dir_tx = 1'b0; bus_size = bs; blk_len = 12'(len_code); enable = 1'b1; dat_in = 4'hF;
    @(negedge clk);
    enable = 1'b0;
    chk(!busy && dat_oe == 0, "R4", "receive armed, lines not driven", {busy, dat_oe}, 0);
    @(negedge clk);
    dat_in = wide ? 4'h0 : 4'hE;
    for (int s = 0; s < nb * spb; s++) begin
      logic [7:0] b;
      int j;
      @(negedge clk);
      if (s == 0) chk(busy, "R9", "busy after start bit", busy, 1);
      if (rx_valid) begin
        if (rcount >= nb || rx_data !== pat(seed, rcount)) rx_bad++;
        rcount++;
      end
      if (dat_oe != 0) bad_oe++;
      b = pat(seed, s / spb);
      j = s % spb;
      v = wide ? ((j == 0) ? b[7:4] : b[3:0]) : {3'b111, b[7-j]};
      dat_in = v;
      for (int l = 0; l < 4; l++) crc[l] = crc_upd(crc[l], wide ? v[l] : ((l == 0) ? v[0] : 1'b0));
    end
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (rx_valid) begin
        if (rcount >= nb || rx_data !== pat(seed, rcount)) rx_bad++;
        rcount++;
      end
      for (int l = 0; l < 4; l++) v[l] = crc[l][15-i];
      if (!wide) v = {3'b111, v[0]};
      if (crc_bad && i == 3) v[wide ? 2 : 0] = ~v[wide ? 2 : 0];
      dat_in = v;
    end
    @(negedge clk);
    if (end_bad) dat_in = wide ? 4'h7 : 4'hE;
    else         dat_in = 4'hF;
    @(negedge clk);
    chk(eob && !busy, "R9", "receive end of block", {eob, busy}, 2'b10);
    chk(crc_err == crc_bad, "R10", "crc error flag", crc_err, crc_bad);
    chk(fmt_err == end_bad, "R11", "format error flag", fmt_err, end_bad);
    chk(rcount == nb && rx_bad == 0, rq, "received bytes", rcount - rx_bad, nb);
    chk(bad_oe == 0 && dat_oe == 0, "R4", "no drive during receive", bad_oe, 0);
    dat_in = 4'hF;
    @(negedge clk);
    chk(!eob && !crc_err && !fmt_err, "R10", "flags clear after pulse",
        {eob, crc_err, fmt_err}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_size = 2'd0; dir_tx = 1'b0; enable = 1'b0; blk_len = '0;
    tx_data = '0; tx_valid = 1'b0; dat_in = 4'hF;
    repeat (3) @(negedge clk);
    chk(!busy && !eob && dat_oe == 0 && !tx_ready && !rx_valid, "R4", "reset state",
        {busy, eob, dat_oe, tx_ready, rx_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && dat_oe == 0, "R8", "idle after reset", {busy, dat_oe}, 0);

    tx_frame(2'd0, 3, 5, 4, "R1");
    tx_frame(2'd1, 5, 9, 2, "R2");
    tx_frame(2'd2, 2, 17, 1, "R3");
    tx_frame(2'd3, 1, 33, 3, "R3");
    tx_frame(2'd1, 0, 41, 1, "R7");
    rx_frame(2'd0, 4, 3, 1'b0, 1'b0, "R1");
    rx_frame(2'd1, 6, 7, 1'b0, 1'b0, "R2");
    rx_frame(2'd1, 3, 11, 1'b1, 1'b0, "R6");
    rx_frame(2'd0, 2, 13, 1'b0, 1'b1, "R9");
    rx_frame(2'd1, 2, 19, 1'b0, 1'b1, "R9");
    rx_frame(2'd3, 2, 23, 1'b0, 1'b0, "R3");
    rx_frame(2'd0, 1, 29, 1'b1, 1'b0, "R9");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule